// File: doc/BRIEF.md
# Oversampling Manchester Burst Receiver

This block takes a single serial line that rests high and recovers one 16-bit word from each framed burst sent on it. Each burst is a start bit, sixteen data bits sent least-significant first, and a stop bit. Every bit carries a transition at its centre: a rise for a one and a fall for a zero. The block samples the line with a clock running at sixteen times the nominal bit rate. It needs no phase-locked loop.

The receiver synchronises the line and treats the first fall from rest as the opening half of the start bit. After that it measures time only from the last accepted mid-bit transition. An edge that arrives early, near a bit boundary, is ignored. The first edge after that blanking window is taken as the next mid-bit transition. This resynchronisation on every bit lets the receiver follow a transmitter whose rate differs from nominal by roughly 18%.

A burst with a good stop bit produces the word and a one-cycle valid strobe. A zero stop bit, or a line that stops toggling, produces a one-cycle framing-error pulse instead. After an error the receiver waits for a quiet line before it hunts for a new frame.

Top module: `mbr_receiver`

## Requirements
- R1: While reset is high and in the first cycle after it, `rx_valid`, `frame_err` and `line_idle` are 0 and `rx_word` is 0.
- R2: `line_idle` is 1 only when the synchronised line has been high for at least 32 consecutive sample cycles and no frame is in progress. It falls in the cycle after the synchronised line falls, and it stays 0 for the whole of a frame.
- R3: A frame starts on a falling edge of the synchronised line while the receiver is hunting. The first edge seen after that fall is the start bit's mid-bit rise. Each data bit decodes as 1 for a mid-bit rise and as 0 for a mid-bit fall. The first data bit received is placed in `rx_word[0]` and the sixteenth in `rx_word[15]`.
- R4: After a stop bit that decodes as 1, `rx_valid` is high for exactly one cycle. `rx_word` then holds that word and changes only in a cycle where `rx_valid` is high.
- R5: A stop bit that decodes as 0 gives a one-cycle `frame_err` pulse, gives no strobe, and leaves `rx_word` unchanged.
- R6: Any edge that arrives fewer than 13 sample cycles after an accepted mid-bit edge is ignored. This covers bit-boundary edges and short glitches.
- R7: If no edge is accepted within 24 sample cycles of the last accepted edge (or of the start fall), the frame is abandoned with a one-cycle `frame_err` pulse and no strobe.
- R8: After any framing error, falling edges are ignored until the line has been high for 32 consecutive sample cycles.
- R9: `rx_valid` and `frame_err` are never high in the same cycle.
- R10: Bursts whose bit period is anywhere from 13 to 19 sample cycles decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16x the nominal bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial line, high at rest |
| rx_word | output | 16 | Last word received with a good stop bit |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit or a timeout |
| line_idle | output | 1 | Line quiet and no frame in progress |

## Verification
The embedded properties check on every cycle that the strobe and the error pulse each last one cycle and never coincide, and that the word changes only with the strobe. They also check that the time since the last accepted edge never passes the timeout limit, and that the idle flag drops right after the line falls.

Other behaviours can only be shown by the bench's scenarios:
- correct bit values and bit order;
- tolerance of fast and slow bit periods;
- rejection of mid-bit glitches;
- the error paths for a zero stop bit, a stalled line and a stuck start bit;
- the refusal to start a new frame until the line has been quiet.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    // Default geometry of the burst
    localparam int WORD_W_D = 16;  // data bits per burst
    localparam int OVS_D    = 16;  // sample cycles per nominal bit

    // Receiver sequencing states
    typedef enum logic [1:0] {
        ST_HUNT,     // waiting for a fall from rest
        ST_START,    // inside the start bit, awaiting its centre rise
        ST_BITS,     // tracking data and stop bits
        ST_RECOVER   // after an error, waiting for a quiet line
    } rx_state_e;

    // Synchronised line view
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_t;

    // One accepted mid-bit transition
    typedef struct packed {
        logic valid;  // an edge was accepted this cycle
        logic value;  // decoded bit (line level after the edge)
        logic last;   // this edge belongs to the stop bit
    } bit_evt_t;

    // Blanking limit: three quarters of a nominal bit
    function automatic int blank_cycles(input int ovs);
        return (ovs * 3) / 4;
    endfunction

    // Timeout limit: one and a half nominal bits
    function automatic int timeout_cycles(input int ovs);
        return (ovs * 3) / 2;
    endfunction

endpackage

// File: rtl/mbr_line_sync.sv
module mbr_line_sync
    import mbr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_in,
    output line_t line_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Flops reset to the rest level so that no false fall appears after reset
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        line_o.level = chain_q[STAGES-1];
        line_o.rise  = chain_q[STAGES-1] & ~last_q;
        line_o.fall  = ~chain_q[STAGES-1] & last_q;
    end

endmodule

// File: rtl/mbr_idle_watch.sv
module mbr_idle_watch #(
    parameter int QUIET_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic quiet
);

    localparam int RW = $clog2(QUIET_CYC + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(QUIET_CYC);

    logic [RW-1:0] run_q;

    // Length of the current high run, held at the limit once reached
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!level) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign quiet = (run_q == RUN_MAX);

endmodule

// File: rtl/mbr_bit_tracker.sv
module mbr_bit_tracker
    import mbr_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int BLANK   = 12,
    parameter int TIMEOUT = 24
) (
    input  logic     clk,
    input  logic     rst,
    input  line_t    line_i,
    input  logic     quiet,
    output bit_evt_t evt_o,
    output logic     abort_o,
    output logic     busy_o
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam int IW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] BLANK_V = CW'(BLANK);
    localparam logic [CW-1:0] TMO_V   = CW'(TIMEOUT);
    localparam logic [IW-1:0] STOP_V  = IW'(WORD_W);

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;   // cycles since the last accepted edge
    logic [IW-1:0] idx_q;   // index of the bit now expected
    logic          any_edge;
    logic          take_start;
    logic          take_bit;
    logic          in_frame;

    always_comb begin
        any_edge   = line_i.rise | line_i.fall;
        in_frame   = (state_q == ST_START) || (state_q == ST_BITS);
        take_start = (state_q == ST_START) && line_i.rise;
        take_bit   = (state_q == ST_BITS) && any_edge && (cnt_q >= BLANK_V);

        evt_o.valid = take_bit;
        evt_o.value = line_i.level;
        evt_o.last  = (idx_q == STOP_V);

        abort_o = in_frame && !take_start && !take_bit && (cnt_q == TMO_V);
        busy_o  = in_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (line_i.fall) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (take_start) begin
                        state_q <= ST_BITS;
                        cnt_q   <= '0;
                        idx_q   <= '0;
                    end else if (abort_o) begin
                        state_q <= ST_RECOVER;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (take_bit) begin
                        cnt_q <= '0;
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == STOP_V) begin
                            state_q <= line_i.level ? ST_HUNT : ST_RECOVER;
                        end
                    end else if (abort_o) begin
                        state_q <= ST_RECOVER;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (quiet) begin
                        state_q <= ST_HUNT;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // Elapsed time since the last accepted edge stays within the timeout
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TMO_V);  // R7

    // A recovering receiver does not leave that state before the line is quiet
    AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOVER && !quiet) |=> (state_q == ST_RECOVER));  // R8

endmodule

// File: rtl/mbr_word_asm.sv
module mbr_word_asm
    import mbr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt_i,
    input  logic              abort_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o
);

    logic [WORD_W-1:0] shift_q;
    logic              good_stop;
    logic              bad_stop;

    always_comb begin
        good_stop = evt_i.valid && evt_i.last && evt_i.value;
        bad_stop  = evt_i.valid && evt_i.last && !evt_i.value;
    end

    // Bits arrive least significant first: shift in from the top
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (evt_i.valid && !evt_i.last) begin
            shift_q <= {evt_i.value, shift_q[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= good_stop;
            err_o   <= bad_stop || abort_i;
            if (good_stop) begin
                word_o <= shift_q;
            end
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);  // R4

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(word_o));  // R4

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);  // R5

    AST_STB_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o));  // R9

endmodule

// File: rtl/mbr_receiver.sv
module mbr_receiver
    import mbr_pkg::*;
#(
    parameter int WORD_W = WORD_W_D,
    parameter int OVS    = OVS_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              line_idle
);

    localparam int BLANK_CYC = blank_cycles(OVS);
    localparam int TMO_CYC   = timeout_cycles(OVS);
    localparam int QUIET_CYC = 2 * OVS;

    line_t    line_s;
    logic     quiet;
    logic     busy;
    logic     abort;
    bit_evt_t evt;

    mbr_line_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_in(line_in),
        .line_o (line_s)
    );

    mbr_idle_watch #(.QUIET_CYC(QUIET_CYC)) u_idle (
        .clk  (clk),
        .rst  (rst),
        .level(line_s.level),
        .quiet(quiet)
    );

    mbr_bit_tracker #(
        .WORD_W (WORD_W),
        .BLANK  (BLANK_CYC),
        .TIMEOUT(TMO_CYC)
    ) u_track (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_s),
        .quiet  (quiet),
        .evt_o  (evt),
        .abort_o(abort),
        .busy_o (busy)
    );

    mbr_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .abort_i(abort),
        .word_o (rx_word),
        .valid_o(rx_valid),
        .err_o  (frame_err)
    );

    assign line_idle = quiet && !busy;

    // Idle status clears the cycle after the synchronised line falls
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(line_s.level) |=> !line_idle);  // R2

endmodule

// File: tb/mbr_receiver_test.sv
`timescale 1ns/1ps
module mbr_receiver_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b1;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic        frame_err;
    logic        line_idle;

    mbr_receiver uut (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .rx_word  (rx_word),
        .rx_valid (rx_valid),
        .frame_err(frame_err),
        .line_idle(line_idle)
    );

    always #4 clk = ~clk;  // 125 MHz

    int          n_checks = 0;
    int          n_errors = 0;
    int          n_valid = 0;
    int          n_ferr = 0;
    int          n_both = 0;
    int          idle_busy = 0;
    logic [15:0] last_word = '0;
    logic        chk_busy = 1'b0;

    // Event monitor: samples on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid++;
                last_word = rx_word;
            end
            if (frame_err) n_ferr++;
            if (rx_valid && frame_err) n_both++;
            if (chk_busy && line_idle) idle_busy++;
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic lv, input int n);
        line_in = lv;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int per, input bit glitch);
        int h1 = per / 2;
        int h2 = per - h1;
        hold(~b, h1);
        if (glitch) begin
            hold(b, 3);
            hold(~b, 2);
            hold(b, h2 - 5);
        end else begin
            hold(b, h2);
        end
    endtask

    // cut_at >= 0 stalls the line before that data bit
    task automatic send_frame(input logic [15:0] w, input int per, input logic stop_v,
                              input int glitch_at, input int cut_at, input int gap);
        send_bit(1'b1, per, 1'b0);
        chk_busy = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (i == cut_at) begin
                chk_busy = 1'b0;
                hold(line_in, 40);
                hold(1'b1, 48);
                return;
            end
            send_bit(w[i], per, i == glitch_at);
        end
        chk_busy = 1'b0;
        send_bit(stop_v, per, 1'b0);
        hold(1'b1, gap);
    endtask

    // Table: word and bit period in sample cycles
    localparam int NV = 7;
    localparam logic [15:0] TV_WORD [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001,
                                             16'h1234, 16'h7E5A, 16'hC0DE};
    localparam int TV_PER [NV] = '{16, 16, 16, 13, 19, 13, 19};

    bit done = 1'b0;

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int v0;
        int e0;
        logic [15:0] w0;

        repeat (5) @(negedge clk);
        check_eq("R1 valid in reset", 32'(rx_valid), 0);
        check_eq("R1 err in reset", 32'(frame_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 valid after reset", 32'(rx_valid), 0);
        check_eq("R1 err after reset", 32'(frame_err), 0);
        check_eq("R1 word after reset", 32'(rx_word), 0);
        check_eq("R1 idle after reset", 32'(line_idle), 0);
        repeat (40) @(negedge clk);
        check_eq("R2 idle on quiet line", 32'(line_idle), 1);

        // Table of good bursts, nominal, fast and slow rates
        for (int k = 0; k < NV; k++) begin
            v0 = n_valid;
            e0 = n_ferr;
            send_frame(TV_WORD[k], TV_PER[k], 1'b1, -1, -1, 48);
            check_eq("R4 one strobe per burst", 32'(n_valid - v0), 1);
            check_eq("R3 no error on good burst", 32'(n_ferr - e0), 0);
            check_eq((TV_PER[k] == 16) ? "R3 word value" : "R10 word at off rate",
                     32'(last_word), 32'(TV_WORD[k]));
            check_eq("R4 word held on port", 32'(rx_word), 32'(TV_WORD[k]));
            check_eq("R2 idle after burst", 32'(line_idle), 1);
        end
        check_eq("R2 idle low inside bursts", 32'(idle_busy), 0);

        // Zero stop bit
        v0 = n_valid; e0 = n_ferr; w0 = rx_word;
        send_frame(16'h5555, 16, 1'b0, -1, -1, 48);
        check_eq("R5 error on zero stop", 32'(n_ferr - e0), 1);
        check_eq("R5 no strobe on zero stop", 32'(n_valid - v0), 0);
        check_eq("R5 word unchanged", 32'(rx_word), 32'(w0));

        // Glitch right after a mid-bit edge
        v0 = n_valid; e0 = n_ferr;
        send_frame(16'h3C96, 16, 1'b1, 5, -1, 48);
        check_eq("R6 glitch ignored strobe", 32'(n_valid - v0), 1);
        check_eq("R6 glitch ignored word", 32'(rx_word), 32'h3C96);
        check_eq("R6 glitch no error", 32'(n_ferr - e0), 0);

        // Line stalls mid-frame
        v0 = n_valid; e0 = n_ferr;
        send_frame(16'h00F0, 16, 1'b1, -1, 4, 48);
        check_eq("R7 stall error", 32'(n_ferr - e0), 1);
        check_eq("R7 stall no strobe", 32'(n_valid - v0), 0);

        // Start bit never rises
        v0 = n_valid; e0 = n_ferr;
        hold(1'b0, 40);
        hold(1'b1, 48);
        check_eq("R7 start timeout error", 32'(n_ferr - e0), 1);
        check_eq("R7 start timeout no strobe", 32'(n_valid - v0), 0);

        // Burst too soon after an error is ignored
        v0 = n_valid; e0 = n_ferr;
        send_frame(16'h1111, 16, 1'b0, -1, -1, 10);
        send_frame(16'hBEEF, 16, 1'b1, -1, -1, 48);
        check_eq("R8 only the first error", 32'(n_ferr - e0), 1);
        check_eq("R8 early burst ignored", 32'(n_valid - v0), 0);
        v0 = n_valid;
        send_frame(16'h2468, 16, 1'b1, -1, -1, 48);
        check_eq("R8 accepted after quiet", 32'(n_valid - v0), 1);
        check_eq("R8 word after quiet", 32'(rx_word), 32'h2468);

        check_eq("R9 strobe and error never together", 32'(n_both), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule